// File: doc/BRIEF.md
# Multi-Channel DMA Command and Completion Register Front End

This block sits between a register bus and a sixteen-channel DMA engine. Software starts work on a channel by writing a command pointer word into that channel's command slot. Each channel holds up to two such words in a small queue, and the engine takes them from the head of the queue. On the engine side, completion results are pushed, tagged with a channel number. Each result that passes the channel's configuration filter goes into a per-channel result FIFO. Software drains that FIFO one word per read.

A per-channel status word shows live state: whether the command queue can accept another word, whether results are waiting, a sticky overflow flag, and both occupancy counts. A shared interrupt register holds one pending bit per channel. A single read of it returns every pending bit and clears them all. The engine can also deposit six diagnostic words per channel, which software reads after a failed transfer. Writing zero to the first of these words sends a flush request pulse to the engine.

The bus uses word addresses. Bits 7:4 select a register group and bits 3:0 select the channel. The groups are: 0 command, 1 result, 2 to 7 diagnostic words 0 to 5, 8 status, 12 config, 14 interrupt status (channel field ignored). Reads return data one cycle after the request.

Top module: `dmx_chan_regs`

## Requirements
- R1: After reset every channel's status reads 0x00000001, the interrupt status reads 0, and `irq` is low.
- R2: A write to a channel's command group queues the word if fewer than 2 are held. Status bits 28:27 give the held count, and bit 0 (ready) is 1 exactly while the count is below 2. A write made while the queue is full is ignored.
- R3: `cmd_head_vld[c]` is high while channel c holds a command, and `cmd_head_ptr` slice c shows the oldest one. A pulse on `cmd_take[c]` removes it, so words leave in write order.
- R4: A pushed result word is kept only if at least one of these holds: bit 3 (error) is set; bit 0 (user) is set; bit 1 (done) is set and config bit 2 is set; bit 2 (flush) is set and config bit 1 is set. Otherwise it is discarded. Config bit 0 is the interrupt enable.
- R5: Each read of a channel's result group returns the oldest kept word with bit 31 forced to 1 and removes it. A read of an empty FIFO returns 0. Status bit 1 is 1 while entries remain, and status bits 31:29 give their count.
- R6: A push and a result read to the same channel in the same cycle leave the count unchanged when the FIFO is not empty.
- R7: A kept result pushed into a full FIFO of depth 4 (with no read in the same cycle) is dropped and sets status bit 2. The flag stays set until reset.
- R8: A kept result sets the channel's bit in the interrupt status when config bit 0 is 1. Reading the interrupt status returns all pending bits and clears them. `irq` is high while any bit is pending.
- R9: A bit set in the same cycle as an interrupt-status read is not lost. It appears in the next read.
- R10: Writing 0 to diagnostic word 0 of channel c drives `flush_req[c]` high for exactly one cycle. Any nonzero write drives no pulse.
- R11: Diagnostic word k (0 to 5) of channel c reads back the last value the engine wrote for that channel and index.
- R12: `bus_rvalid` is high in the cycle after a read request, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Word address: group in 7:4, channel in 3:0 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| cmd_head_vld | output | 16 | Per-channel command waiting |
| cmd_head_ptr | output | 512 | Oldest command word per channel, 32 bits each |
| cmd_take | input | 16 | Engine removes the head command of a channel |
| eng_rslt_push | input | 1 | Engine pushes a result |
| eng_rslt_ch | input | 4 | Channel of the pushed result |
| eng_rslt_word | input | 32 | Result word |
| eng_flush_we | input | 1 | Engine writes a diagnostic word |
| eng_flush_ch | input | 4 | Channel of the diagnostic word |
| eng_flush_idx | input | 3 | Index 0 to 5 of the diagnostic word |
| eng_flush_data | input | 32 | Diagnostic word value |
| flush_req | output | 16 | One-cycle flush request per channel |
| irq | output | 1 | Shared interrupt, high while any bit is pending |

## Verification
The assertions assume that the engine raises `cmd_take` only for a channel whose `cmd_head_vld` is high, and that the bus never raises read and write strobes together. The bench honours both: it takes commands only after checking that the head is valid, and its bus tasks issue one kind of access at a time. The FIFO count properties also assume a clean synchronous reset before the first strobe, which the bench applies for several cycles. Same-cycle cases, such as a push together with a pop or a set together with a clear, are driven by hand so that both events reach the same clock edge.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int WORD_W = 32;

  // register groups (bus_addr[7:4])
  localparam logic [3:0] GRP_CMD  = 4'h0;
  localparam logic [3:0] GRP_RSLT = 4'h1;
  localparam logic [3:0] GRP_DG0  = 4'h2;
  localparam logic [3:0] GRP_DG5  = 4'h7;
  localparam logic [3:0] GRP_STAT = 4'h8;
  localparam logic [3:0] GRP_CFG  = 4'hC;
  localparam logic [3:0] GRP_ISR  = 4'hE;

  // result word bits
  localparam int RB_VALID = 31;
  localparam int RB_ERR   = 3;
  localparam int RB_FLUSH = 2;
  localparam int RB_DONE  = 1;
  localparam int RB_USER  = 0;

  // config bits
  localparam int CF_IRQ   = 0;
  localparam int CF_FLUSH = 1;
  localparam int CF_TOP   = 2;

  function automatic logic rslt_keep(input logic [WORD_W-1:0] w, input logic [2:0] cfg);
    return w[RB_ERR] | w[RB_USER] | (w[RB_DONE] & cfg[CF_TOP]) | (w[RB_FLUSH] & cfg[CF_FLUSH]);
  endfunction
endpackage

// File: rtl/dmx_fifo.sv
module dmx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_pop, do_push;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_push_pop_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> (count == $past(count)));
  assert_full_ignore_R2: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
#(
  parameter int CQ_DEPTH = 2,
  parameter int RQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              cmd_take,
  input  logic              cfg_wr,
  input  logic              rslt_push,
  input  logic [WORD_W-1:0] rslt_word,
  input  logic              rslt_pop,
  output logic              cmd_vld,
  output logic [WORD_W-1:0] cmd_ptr,
  output logic [WORD_W-1:0] status,
  output logic [2:0]        cfg,
  output logic [WORD_W-1:0] rslt_head,
  output logic              rslt_kept
);
  localparam int CQ_CW = $clog2(CQ_DEPTH + 1);
  localparam int RQ_CW = $clog2(RQ_DEPTH + 1);

  logic [CQ_CW-1:0]  c_cnt;
  logic              c_full, c_empty;
  logic [RQ_CW-1:0]  r_cnt;
  logic              r_full, r_empty, ovf, r_drop;
  logic [WORD_W-1:0] r_head;

  dmx_fifo #(.DEPTH(CQ_DEPTH), .W(WORD_W)) u_cq (
    .clk(clk), .rst(rst), .push(cmd_wr), .din(wdata), .pop(cmd_take),
    .head(cmd_ptr), .count(c_cnt), .full(c_full), .empty(c_empty));

  assign rslt_kept = rslt_push && rslt_keep(rslt_word, cfg);
  assign r_drop    = rslt_kept && r_full && !rslt_pop;

  dmx_fifo #(.DEPTH(RQ_DEPTH), .W(WORD_W)) u_rq (
    .clk(clk), .rst(rst), .push(rslt_kept),
    .din(rslt_word | (WORD_W'(1) << RB_VALID)), .pop(rslt_pop),
    .head(r_head), .count(r_cnt), .full(r_full), .empty(r_empty));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      ovf <= 1'b0;
    end else begin
      if (cfg_wr) cfg <= wdata[2:0];
      if (r_drop) ovf <= 1'b1;
    end
  end

  assign cmd_vld   = !c_empty;
  assign rslt_head = r_empty ? '0 : r_head;
  assign status    = {3'(r_cnt), 2'(c_cnt), 24'b0, ovf, !r_empty, !c_full};

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    r_drop |=> (status[2] && $stable(r_cnt)));
endmodule

// File: rtl/dmx_diag_mem.sv
module dmx_diag_mem #(
  parameter int NUM_CH = 16,
  parameter int NREG   = 6,
  parameter int W      = 32,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int DEP   = NUM_CH * NREG,
  localparam int MW    = $clog2(DEP)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [CH_W-1:0] wch,
  input  logic [2:0]      widx,
  input  logic [W-1:0]    wdata,
  input  logic [CH_W-1:0] rch,
  input  logic [2:0]      ridx,
  output logic [W-1:0]    rdata
);
  logic [W-1:0] mem [DEP];
  logic [MW-1:0] wa, ra;

  assign wa = MW'(wch) * MW'(NREG) + MW'(widx);
  assign ra = MW'(rch) * MW'(NREG) + MW'(ridx);

  always_ff @(posedge clk) begin
    if (we && (widx < 3'(NREG))) mem[wa] <= wdata;
    rdata <= mem[ra];
  end
endmodule

// File: rtl/dmx_chan_regs.sv
module dmx_chan_regs
  import dmx_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int CQ_DEPTH = 2,
  parameter int RQ_DEPTH = 4,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [7:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic [WORD_W-1:0]        bus_wdata,
  input  logic                     bus_rd,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  output logic [NUM_CH-1:0]        cmd_head_vld,
  output logic [NUM_CH*WORD_W-1:0] cmd_head_ptr,
  input  logic [NUM_CH-1:0]        cmd_take,
  input  logic                     eng_rslt_push,
  input  logic [CH_W-1:0]          eng_rslt_ch,
  input  logic [WORD_W-1:0]        eng_rslt_word,
  input  logic                     eng_flush_we,
  input  logic [CH_W-1:0]          eng_flush_ch,
  input  logic [2:0]               eng_flush_idx,
  input  logic [WORD_W-1:0]        eng_flush_data,
  output logic [NUM_CH-1:0]        flush_req,
  output logic                     irq
);
  logic [3:0]        grp;
  logic [CH_W-1:0]   ch;
  logic              isr_rd, grp_dg;
  logic [2:0]        dg_idx;
  logic [NUM_CH-1:0] isr, isr_set, isr_nxt, kept;
  logic [WORD_W-1:0] stat_w [NUM_CH];
  logic [WORD_W-1:0] head_w [NUM_CH];
  logic [2:0]        cfg_w  [NUM_CH];
  logic [WORD_W-1:0] word_q, dg_rdata;
  logic              sel_dg_q;

  assign grp    = bus_addr[7:4];
  assign ch     = bus_addr[CH_W-1:0];
  assign isr_rd = bus_rd && (grp == GRP_ISR);
  assign grp_dg = (grp >= GRP_DG0) && (grp <= GRP_DG5);
  assign dg_idx = grp_dg ? 3'(grp - GRP_DG0) : 3'd0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (ch == CH_W'(c));
    dmx_chan #(.CQ_DEPTH(CQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)) u_chan (
      .clk(clk), .rst(rst),
      .cmd_wr(bus_wr && hit && (grp == GRP_CMD)),
      .wdata(bus_wdata),
      .cmd_take(cmd_take[c]),
      .cfg_wr(bus_wr && hit && (grp == GRP_CFG)),
      .rslt_push(eng_rslt_push && (eng_rslt_ch == CH_W'(c))),
      .rslt_word(eng_rslt_word),
      .rslt_pop(bus_rd && hit && (grp == GRP_RSLT)),
      .cmd_vld(cmd_head_vld[c]),
      .cmd_ptr(cmd_head_ptr[c*WORD_W +: WORD_W]),
      .status(stat_w[c]),
      .cfg(cfg_w[c]),
      .rslt_head(head_w[c]),
      .rslt_kept(kept[c]));
    assign isr_set[c] = kept[c] && cfg_w[c][CF_IRQ];

    always_ff @(posedge clk) begin
      if (rst) flush_req[c] <= 1'b0;
      else     flush_req[c] <= bus_wr && hit && (grp == GRP_DG0) && (bus_wdata == '0);
    end
  end

  dmx_diag_mem #(.NUM_CH(NUM_CH), .NREG(6), .W(WORD_W)) u_diag (
    .clk(clk), .we(eng_flush_we), .wch(eng_flush_ch), .widx(eng_flush_idx),
    .wdata(eng_flush_data), .rch(ch), .ridx(dg_idx), .rdata(dg_rdata));

  assign isr_nxt = (isr_rd ? '0 : isr) | isr_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr        <= '0;
      irq        <= 1'b0;
      bus_rvalid <= 1'b0;
      sel_dg_q   <= 1'b0;
      word_q     <= '0;
    end else begin
      isr        <= isr_nxt;
      irq        <= |isr_nxt;
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        sel_dg_q <= grp_dg;
        case (grp)
          GRP_RSLT: word_q <= head_w[ch];
          GRP_STAT: word_q <= stat_w[ch];
          GRP_CFG:  word_q <= WORD_W'(cfg_w[ch]);
          GRP_ISR:  word_q <= WORD_W'(isr);
          default:  word_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = sel_dg_q ? dg_rdata : word_q;

  assert_isr_return_R8: assert property (@(posedge clk) disable iff (rst)
    isr_rd |=> (bus_rdata[NUM_CH-1:0] == $past(isr)));
  assert_isr_keep_new_R9: assert property (@(posedge clk) disable iff (rst)
    isr_rd |=> (isr == $past(isr_set)));
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    (isr != '0) |-> irq);
  assert_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/dmx_chan_regs_bench.sv
module dmx_chan_regs_bench;
  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid;
  logic [15:0] cmd_head_vld, cmd_take = 0, flush_req;
  logic [511:0] cmd_head_ptr;
  logic eng_rslt_push = 0, eng_flush_we = 0, irq;
  logic [3:0] eng_rslt_ch = 0, eng_flush_ch = 0;
  logic [2:0] eng_flush_idx = 0;
  logic [31:0] eng_rslt_word = 0, eng_flush_data = 0;
  int checks = 0, fails = 0;
  logic [31:0] got;
  bit done = 0;

  always #4 clk = ~clk;

  dmx_chan_regs u_dmx_chan_regs (.*);

  function automatic logic [7:0] ad(input int g, input int c);
    return {4'(g), 4'(c)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic push(input int c, input logic [31:0] w);
    @(negedge clk); eng_rslt_ch = 4'(c); eng_rslt_word = w; eng_rslt_push = 1;
    @(negedge clk); eng_rslt_push = 0;
  endtask

  task automatic take(input int c);
    @(negedge clk); cmd_take[c] = 1;
    @(negedge clk); cmd_take = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int c = 0; c < 16; c++) begin
      rd(ad(8, c), got); chk("R1 status", got, 32'h1);
    end
    rd(ad(14, 0), got); chk("R1 isr", got, 0);
    chk("R1 irq", 32'(irq), 0);
    // R12 read valid timing
    chk("R12 rvalid after read", 32'(bus_rvalid), 1);
    @(negedge clk); chk("R12 rvalid idle", 32'(bus_rvalid), 0);

    // R2 command queue fill, sweep all channels
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 3; k++) begin
        wr(ad(0, c), 32'h2000_0000 | (c << 8) | k);
        rd(ad(8, c), got);
        chk("R2 status count/ready", got,
            (k >= 1) ? 32'h1000_0000 : 32'h0800_0001);
      end
    end
    // R3 head order and take
    for (int c = 0; c < 16; c++) begin
      chk("R3 head valid", 32'(cmd_head_vld[c]), 1);
      chk("R3 head first", cmd_head_ptr[c*32 +: 32], 32'h2000_0000 | (c << 8));
      take(c);
      chk("R3 head second", cmd_head_ptr[c*32 +: 32], 32'h2000_0001 | (c << 8));
      take(c);
      chk("R3 drained", 32'(cmd_head_vld[c]), 0);
      rd(ad(8, c), got); chk("R2 status after drain", got, 32'h1);
    end

    // R4 filter sweep on channel 3, with R5/R8 readback
    for (int cf = 0; cf < 8; cf++) begin
      wr(ad(12, 3), cf);
      rd(ad(12, 3), got); chk("R4 cfg readback", got, cf);
      for (int cs = 0; cs < 16; cs++) begin
        logic acc;
        logic [31:0] w;
        w = 32'(cs) | (32'(cs) << 12);
        acc = cs[3] | cs[0] | (cs[1] & cf[2]) | (cs[2] & cf[1]);
        push(3, w);
        rd(ad(8, 3), got);
        chk("R4 kept flag", got, acc ? 32'h2000_0003 : 32'h1);
        if (acc) begin
          rd(ad(1, 3), got); chk("R5 result word", got, w | 32'h8000_0000);
        end
        rd(ad(14, 0), got);
        chk("R8 isr after push", got, (acc && cf[0]) ? 32'h8 : 0);
        chk("R8 irq cleared", 32'(irq), 0);
      end
    end

    // R5 / R7 overflow on channel 9
    wr(ad(12, 9), 1);
    for (int k = 0; k < 5; k++) push(9, 32'h8 | (k << 4));
    rd(ad(8, 9), got); chk("R7 overflow status", got, 32'h8000_0007);
    chk("R8 irq high", 32'(irq), 1);
    for (int k = 0; k < 4; k++) begin
      rd(ad(1, 9), got); chk("R5 fifo order", got, 32'h8000_0008 | (k << 4));
    end
    rd(ad(1, 9), got); chk("R5 empty read", got, 0);
    rd(ad(8, 9), got); chk("R7 sticky after drain", got, 32'h5);
    rd(ad(14, 0), got); chk("R8 isr ch9", got, 32'h200);

    // R6 push and pop together on channel 12
    push(12, 32'h11); push(12, 32'h21);
    @(negedge clk);
    bus_addr = ad(1, 12); bus_rd = 1;
    eng_rslt_ch = 12; eng_rslt_word = 32'h31; eng_rslt_push = 1;
    @(negedge clk); bus_rd = 0; eng_rslt_push = 0;
    chk("R6 popped word", bus_rdata, 32'h8000_0011);
    rd(ad(8, 12), got); chk("R6 count kept", got, 32'h4000_0003);
    rd(ad(1, 12), got); chk("R6 order a", got, 32'h8000_0021);
    rd(ad(1, 12), got); chk("R6 order b", got, 32'h8000_0031);

    // R9 set during clearing read
    wr(ad(12, 2), 1); wr(ad(12, 5), 1);
    push(2, 32'h8);
    chk("R8 irq set", 32'(irq), 1);
    @(negedge clk);
    bus_addr = ad(14, 0); bus_rd = 1;
    eng_rslt_ch = 5; eng_rslt_word = 32'h8; eng_rslt_push = 1;
    @(negedge clk); bus_rd = 0; eng_rslt_push = 0;
    chk("R9 first read", bus_rdata, 32'h4);
    chk("R9 irq still", 32'(irq), 1);
    rd(ad(14, 0), got); chk("R9 kept bit", got, 32'h20);
    chk("R8 irq low", 32'(irq), 0);

    // R10 flush request
    wr(ad(2, 6), 0);
    chk("R10 pulse", 32'(flush_req), 32'h40);
    @(negedge clk); chk("R10 one cycle", 32'(flush_req), 0);
    wr(ad(2, 6), 5);
    chk("R10 nonzero no pulse", 32'(flush_req), 0);

    // R11 diagnostic words
    for (int c = 0; c < 16; c += 5)
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); eng_flush_we = 1; eng_flush_ch = 4'(c); eng_flush_idx = 3'(k);
        eng_flush_data = 32'hD000_0000 | (c << 8) | k;
        @(negedge clk); eng_flush_we = 0;
      end
    for (int c = 0; c < 16; c += 5)
      for (int k = 0; k < 6; k++) begin
        rd(ad(2 + k, c), got); chk("R11 diag word", got, 32'hD000_0000 | (c << 8) | k);
      end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule